// File: doc/BRIEF.md
# Single-Cycle Subset RISC Datapath

This block is a 32-bit processor core in which every instruction is fetched, decoded, executed and retired within one clock cycle. It supports six instructions: unsigned register add, unsigned register subtract, OR with a zero-extended immediate, word load, word store and branch-if-equal. The core contains a 32-entry register file with two combinational read ports and one clocked write port, an ALU, an immediate extender, the operand and write-back selectors, a decoder, and small word-addressed instruction and data memories.

The core has two states. While `run_en` is low, the processor is frozen. A loader port can then write words into either memory, and two observation ports return one register and one data-memory word combinationally. While `run_en` is high, one instruction retires on every rising clock edge. The reset is asynchronous and active low. Its release is synchronised inside the block, so the core leaves reset two clock edges after `rst_n` rises.

Top module: `sc_datapath`

## Requirements
- R1: After reset the program counter reads 0. While `run_en` is high, each non-branch instruction advances it by 4 bytes. The instruction word is fetched from memory word `pc[7:2]`.
- R2: Opcode 000000 (bits 31:26) with funct 100001 (bits 5:0) writes R[rd] = R[rs] + R[rt] modulo 2^32. The fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11.
- R3: Opcode 000000 with funct 100011 writes R[rd] = R[rs] - R[rt] modulo 2^32.
- R4: Opcode 001101 writes R[rt] = R[rs] OR {16'b0, imm}, where imm is bits 15:0.
- R5: Opcode 100011 writes R[rt] = dmem[(R[rs] + signext(imm)) >> 2].
- R6: Opcode 101011 writes R[rt] to dmem[(R[rs] + signext(imm)) >> 2] and writes no register.
- R7: Opcode 000100 compares R[rs] with R[rt]. If they are equal, the next PC is PC + 4 + signext(imm)*4; otherwise it is PC + 4. It writes neither a register nor memory.
- R8: Register 0 always reads as zero, and any write aimed at it is dropped.
- R9: While `run_en` is low, the PC and the register file hold. `ld_imem_we` or `ld_dmem_we` writes `ld_data` to word `ld_addr` of the chosen memory at the clock edge. `peek_reg_data` and `peek_mem_data` return the selected register and data word in the same cycle.
- R10: An unknown opcode, or an R-type word with any other funct, writes neither a register nor memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High: retire one instruction per cycle; low: core frozen, loader and observation ports active |
| ld_imem_we | input | 1 | Write `ld_data` into instruction memory (only while frozen) |
| ld_dmem_we | input | 1 | Write `ld_data` into data memory (only while frozen) |
| ld_addr | input | 6 | Word address for loader writes |
| ld_data | input | 32 | Word to load |
| peek_reg_sel | input | 5 | Register number to observe |
| peek_reg_data | output | 32 | Contents of the selected register (valid while frozen) |
| peek_mem_addr | input | 6 | Data-memory word to observe |
| peek_mem_data | output | 32 | Contents of the selected data word (valid while frozen) |
| pc_out | output | 32 | Current program counter (byte address) |

## Verification
The bound checker checks on every cycle that the PC stays word-aligned, stays put while frozen and steps by exactly 4 for every non-branch instruction. It also checks that branches and unknown encodings raise no write enable, that a frozen core issues no register write, and that register 0 is observed as zero. The ALU arithmetic, the zero and sign extension, the load and store addressing, the branch outcome and the dropping of a write to register 0 are end-to-end effects. Only the bench's program runs can show them. It runs a fixed program that exercises every instruction, including a negative load offset, a branch that is taken or skipped depending on the data, and two illegal encodings. It repeats that program over a sweep of operand pairs that covers wrap-around, sign-boundary and equal-operand values, and compares every result register and memory word with arithmetic done in the bench.

// File: rtl/scdp_pkg.sv
package scdp_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADDU  = 6'b100001;
  localparam logic [5:0] FN_SUBU  = 6'b100011;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_wr;      // register file write enable
    logic    dst_is_rd;   // write address from rd (1) or rt (0)
    logic    b_is_imm;    // second ALU operand is the extended immediate
    logic    imm_signed;  // sign (1) or zero (0) extension
    logic    wb_from_mem; // write-back from data memory (1) or ALU (0)
    logic    mem_wr;      // data memory write enable
    logic    branch;      // branch-if-equal
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/scdp_ctrl.sv
module scdp_ctrl
  import scdp_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (op)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        if (funct == FN_ADDU) begin
          ctrl.reg_wr = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end else if (funct == FN_SUBU) begin
          ctrl.reg_wr = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.reg_wr   = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.alu_op   = ALU_OR;
      end
      OP_LW: begin
        ctrl.reg_wr      = 1'b1;
        ctrl.b_is_imm    = 1'b1;
        ctrl.imm_signed  = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OP_SW: begin
        ctrl.mem_wr     = 1'b1;
        ctrl.b_is_imm   = 1'b1;
        ctrl.imm_signed = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch     = 1'b1;
        ctrl.imm_signed = 1'b1;
        ctrl.alu_op     = ALU_SUB;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/scdp_alu.sv
module scdp_alu
  import scdp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/scdp_regfile.sv
module scdp_regfile #(
  parameter int unsigned W    = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs_q [NREG];
  logic         wr_ok;

  assign wr_ok = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) regs_q[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
endmodule

// File: rtl/scdp_wordmem.sv
module scdp_wordmem #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import scdp_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 64,
  parameter int unsigned DMEM_DEPTH = 64,
  parameter int unsigned NREG       = 32,
  localparam int unsigned IAW = $clog2(IMEM_DEPTH),
  localparam int unsigned DAW = $clog2(DMEM_DEPTH),
  localparam int unsigned LAW = (IAW > DAW) ? IAW : DAW,
  localparam int unsigned RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            ld_imem_we,
  input  logic            ld_dmem_we,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [RAW-1:0]  peek_reg_sel,
  output logic [XLEN-1:0] peek_reg_data,
  input  logic [DAW-1:0]  peek_mem_addr,
  output logic [XLEN-1:0] peek_mem_data,
  output logic [XLEN-1:0] pc_out
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // fetch
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target;
  logic [XLEN-1:0] instr;
  logic            imem_we;

  assign imem_we = ld_imem_we & ~run_en;

  scdp_wordmem #(.W(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (ld_addr[IAW-1:0]),
    .wdata (ld_data),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  // decode
  logic [5:0]     op, funct;
  logic [RAW-1:0] rs, rt, rd;
  logic [15:0]    imm;
  ctrl_t          ctrl;

  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign imm   = instr[15:0];
  assign funct = instr[5:0];

  scdp_ctrl u_ctrl (
    .op    (op),
    .funct (funct),
    .ctrl  (ctrl)
  );

  // operands
  logic [XLEN-1:0] bus_a, bus_b, imm_ext, alu_b, alu_y, dm_rdata, wb_data;
  logic [RAW-1:0]  rf_raddr_a, rf_waddr;
  logic            rf_we, equal, taken;

  assign rf_raddr_a = run_en ? rs : peek_reg_sel;
  assign rf_waddr   = ctrl.dst_is_rd ? rd : rt;
  assign rf_we      = run_en & ctrl.reg_wr;
  assign wb_data    = ctrl.wb_from_mem ? dm_rdata : alu_y;

  scdp_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (wb_data),
    .raddr_a (rf_raddr_a),
    .raddr_b (rt),
    .rdata_a (bus_a),
    .rdata_b (bus_b)
  );

  assign imm_ext = ctrl.imm_signed ? {{(XLEN-16){imm[15]}}, imm}
                                   : {{(XLEN-16){1'b0}}, imm};
  assign alu_b   = ctrl.b_is_imm ? imm_ext : bus_b;

  scdp_alu #(.W(XLEN)) u_alu (
    .a  (bus_a),
    .b  (alu_b),
    .op (ctrl.alu_op),
    .y  (alu_y)
  );

  // data memory: shared between the running core and the loader/observer
  logic           dm_we;
  logic [DAW-1:0] dm_waddr, dm_raddr;
  logic [XLEN-1:0] dm_wdata;

  assign dm_we    = run_en ? ctrl.mem_wr : ld_dmem_we;
  assign dm_waddr = run_en ? alu_y[DAW+1:2] : ld_addr[DAW-1:0];
  assign dm_wdata = run_en ? bus_b : ld_data;
  assign dm_raddr = run_en ? alu_y[DAW+1:2] : peek_mem_addr;

  scdp_wordmem #(.W(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (dm_raddr),
    .rdata (dm_rdata)
  );

  // next address
  assign equal     = (bus_a == bus_b);
  assign taken     = ctrl.branch & equal;
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};

  always_comb begin
    pc_d = pc_q;
    if (run_en) pc_d = taken ? br_target : pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  assign pc_out        = pc_q;
  assign peek_reg_data = bus_a;
  assign peek_mem_data = dm_rdata;
endmodule

// File: rtl/sc_datapath_chk.sv
module sc_datapath_chk
  import scdp_pkg::*;
(
  input logic        clk,
  input logic        rst_core_n,
  input logic        run_en,
  input logic [31:0] pc_q,
  input logic [5:0]  op,
  input logic [5:0]  funct,
  input logic        rf_we,
  input logic        dm_we,
  input logic [4:0]  peek_reg_sel,
  input logic [31:0] peek_reg_data
);
  logic known_op;
  assign known_op = (op == OP_ORI) || (op == OP_LW) || (op == OP_SW) ||
                    (op == OP_BEQ) ||
                    ((op == OP_RTYPE) && ((funct == FN_ADDU) || (funct == FN_SUBU)));

  // R1
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    pc_q[1:0] == 2'b00);

  // R9
  pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run_en |=> $stable(pc_q));

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en && op != OP_BEQ) |=> pc_q == $past(pc_q) + 32'd4);

  // R7
  beq_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en && op == OP_BEQ) |-> (!rf_we && !dm_we));

  // R10
  undef_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en && !known_op) |-> (!rf_we && !dm_we));

  // R9
  frozen_norf_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run_en |-> !rf_we);

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!run_en && peek_reg_sel == 5'd0) |-> peek_reg_data == 32'd0);
endmodule

bind sc_datapath sc_datapath_chk u_chk (
  .clk           (clk),
  .rst_core_n    (rst_core_n),
  .run_en        (run_en),
  .pc_q          (pc_q),
  .op            (op),
  .funct         (funct),
  .rf_we         (rf_we),
  .dm_we         (dm_we),
  .peek_reg_sel  (peek_reg_sel),
  .peek_reg_data (peek_reg_data)
);

// File: tb/sc_datapath_tb.sv
module sc_datapath_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RUN      = 22;

  logic        clk = 1'b0;
  logic        rst_n, run_en, ld_imem_we, ld_dmem_we;
  logic [5:0]  ld_addr, peek_mem_addr;
  logic [31:0] ld_data, peek_reg_data, peek_mem_data, pc_out;
  logic [4:0]  peek_reg_sel;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_datapath dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_en        (run_en),
    .ld_imem_we    (ld_imem_we),
    .ld_dmem_we    (ld_dmem_we),
    .ld_addr       (ld_addr),
    .ld_data       (ld_data),
    .peek_reg_sel  (peek_reg_sel),
    .peek_reg_data (peek_reg_data),
    .peek_mem_addr (peek_mem_addr),
    .peek_mem_data (peek_mem_data),
    .pc_out        (pc_out)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_word(input bit to_dmem, input int addr, input logic [31:0] data);
    ld_imem_we = !to_dmem;
    ld_dmem_we = to_dmem;
    ld_addr    = 6'(addr);
    ld_data    = data;
    @(negedge clk);
    ld_imem_we = 1'b0;
    ld_dmem_we = 1'b0;
  endtask

  task automatic reg_val(input int r, output logic [31:0] v);
    peek_reg_sel = 5'(r);
    #1 v = peek_reg_data;
  endtask

  task automatic mem_val(input int a, output logic [31:0] v);
    peek_mem_addr = 6'(a);
    #1 v = peek_mem_data;
  endtask

  task automatic run_case(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] prog [16];
    logic [31:0] v;
    prog[0]  = enc_i(6'b001101, 0, 6, 16'h7777);  // ori r6,r0
    prog[1]  = enc_i(6'b100011, 0, 1, 16'd0);     // lw r1,0(r0)
    prog[2]  = enc_i(6'b100011, 0, 2, 16'd4);     // lw r2,4(r0)
    prog[3]  = enc_r(1, 2, 3, 6'b100001);         // addu r3
    prog[4]  = enc_r(1, 2, 4, 6'b100011);         // subu r4
    prog[5]  = enc_i(6'b001101, 1, 5, 16'hA5F0);  // ori r5,r1
    prog[6]  = enc_i(6'b101011, 0, 3, 16'd8);     // sw r3,8(r0)
    prog[7]  = enc_i(6'b101011, 0, 4, 16'd12);    // sw r4,12(r0)
    prog[8]  = enc_i(6'b000100, 1, 2, 16'd1);     // beq r1,r2,+1
    prog[9]  = enc_i(6'b001101, 0, 6, 16'h1111);  // ori r6 (skipped if equal)
    prog[10] = enc_r(1, 2, 0, 6'b100001);         // addu r0 (dropped)
    prog[11] = 32'hFC00_0000;                     // unknown opcode
    prog[12] = enc_i(6'b001101, 0, 9, 16'd20);    // ori r9,r0,20
    prog[13] = enc_i(6'b100011, 9, 8, 16'hFFF8);  // lw r8,-8(r9)
    prog[14] = enc_r(1, 2, 6, 6'b100000);         // unsupported funct
    prog[15] = enc_i(6'b000100, 0, 0, 16'hFFFF);  // halt loop

    rst_n = 1'b0;
    run_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc_out, 32'd0);

    for (int i = 0; i < 16; i++) load_word(1'b0, i, prog[i]);
    load_word(1'b1, 0, a);
    load_word(1'b1, 1, b);
    mem_val(1, v);
    check("R9 loader/peek", v, b);
    check("R9 pc frozen while loading", pc_out, 32'd0);

    run_en = 1'b1;
    @(negedge clk);
    check("R1 pc step", pc_out, 32'd4);
    repeat (8) @(negedge clk);
    check("R7 branch outcome pc", pc_out, (a == b) ? 32'd40 : 32'd36);
    repeat (N_RUN - 9) @(negedge clk);
    run_en = 1'b0;
    check("R7 halt loop pc", pc_out, 32'd60);
    @(negedge clk);
    check("R9 pc holds when frozen", pc_out, 32'd60);

    reg_val(0, v);  check("R8 r0 stays zero", v, 32'd0);
    reg_val(1, v);  check("R5 lw r1", v, a);
    reg_val(2, v);  check("R5 lw r2", v, b);
    reg_val(3, v);  check("R2 addu", v, a + b);
    reg_val(4, v);  check("R3 subu", v, a - b);
    reg_val(5, v);  check("R4 ori zero-ext", v, a | 32'h0000_A5F0);
    reg_val(6, v);  check("R7/R10 r6", v, (a == b) ? 32'h7777 : 32'h1111);
    reg_val(8, v);  check("R5 lw negative offset", v, a - b);
    reg_val(9, v);  check("R4 ori from r0", v, 32'd20);
    mem_val(2, v);  check("R6 sw sum", v, a + b);
    mem_val(3, v);  check("R6 sw diff", v, a - b);
    mem_val(0, v);  check("R10 dmem0 untouched", v, a);
    mem_val(1, v);  check("R10 dmem1 untouched", v, b);
  endtask

  initial begin
    logic [31:0] vals [7];
    vals[0] = 32'd0;
    vals[1] = 32'd1;
    vals[2] = 32'd5;
    vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000;
    vals[5] = 32'hFFFF_FFFF;
    vals[6] = 32'h1234_5678;
    rst_n = 1'b0;
    run_en = 1'b0;
    ld_imem_we = 1'b0;
    ld_dmem_we = 1'b0;
    ld_addr = '0;
    ld_data = '0;
    peek_reg_sel = '0;
    peek_mem_addr = '0;
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        run_case(vals[i], vals[j]);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule